// File: doc/BRIEF.md
# Mailbox Command Processor

This block is the device end of a small command channel. A host reaches it through a window of twelve byte registers. To send a command, the host writes a 16-bit argument into two outgoing bytes and then writes an 8-bit operation code. Writing the code is what starts the operation. After a fixed number of clock cycles the block places a 16-bit result in two incoming bytes and copies the operation code into an acknowledge byte. The host polls that byte: when it equals the code that was sent, the command is finished.

The commands handled here drive an 8-bit relay latch (load it, read it back), keep a bank of 16-bit settings for the neighbouring timing blocks, report any stored setting, and clear the acknowledge byte. Clearing the acknowledge byte is needed when the host wants to send the same command twice in a row. A fourth incoming byte shows the isolated digital inputs. The inputs are synchronised and then sampled on a prescaled tick; with the default settings the tick comes every 100 microseconds at 50 MHz. An interrupt byte carries a host-writable enable. A read-only status byte reports a pending command, a completed command, their combination and the gated interrupt request.

Top module: `mbox_cmd_unit`

## Requirements
- R1: After a synchronous active-low reset, every register in the window reads 0x00, relay_out is 0x00 and irq_o is 0.
- R2: Addresses 0, 1 and 2 hold the argument low byte, the argument high byte and the last code written, and each reads back exactly what was written. Address 3 ignores writes and always reads 0x00.
- R3: A write to address 2 while no command is in flight starts that command. Exactly EXEC_LAT cycles after the write edge, address 6 shows the code, addresses 4 and 5 show the low and high result bytes, and the status byte bit 1 sets. No command stays in flight for BUDGET cycles.
- R4: Code 0x01 loads relay_out from the argument low byte. The argument high byte has no effect. The result is {0x00, new latch}. Code 0x02 returns {0x00, latch} and leaves the latch unchanged.
- R5: Code 0x00 sets address 6 to 0x00 and the result to 0x0000. After it, a repeat of the previous code is seen as a new completion.
- R6: Codes SET_BASE to SET_BASE+SET_N-1 (default 0x10 to 0x1F) each store their full 16-bit argument and return 0x0000. Code 0x03 returns a stored value, chosen by its argument low byte:
  - a code in that range gives the argument stored for it;
  - 0x01 gives {0x00, latch};
  - any other value gives 0x0000.
- R7: Any code not named above is still copied into address 6. Its result is 0x0000 and it leaves the relay latch unchanged.
- R8: A write to address 2 while a command is in flight starts nothing, although address 2 still stores the new byte. The argument is captured when a command starts, so later writes to addresses 0 and 1 do not change the result of the command in flight.
- R9: Address 7 shows the digital inputs after a two-stage synchroniser, sampled once every TICK_DIV cycles. It holds its value between ticks.
- R10: Address 9 bit 5 is the interrupt enable; it is writable and its other bits read 0. Address 10 is the status byte, read only:
  - bit 0 is set while a command is in flight;
  - bit 1 is the completion event;
  - bit 6 is bit 0 OR bit 1;
  - bit 7 is bit 6 AND the enable.

  irq_o equals status bit 7. Addresses 8 and 11 read 0x00.
- R11: A host read of address 6 clears the completion event. If a completion happens in the same cycle as that read, the completion wins and the event stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (reading address 6 clears the completion event) |
| host_addr | input | 4 | Byte address in the register window |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| iso_in | input | 8 | Isolated digital input levels, asynchronous |
| relay_out | output | 8 | Relay latch |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: a command finishing, which sets the completion event, and the host reading the acknowledge byte, which clears it. The bench knows the exact execution latency. It starts a relay load and times a read of address 6 so that the read strobe lands on the completion edge. That read must still return the old acknowledge value. The status byte read on the next cycle must show the completion event still set. A second read of address 6 must then clear the event.

// File: rtl/mbox_pkg.sv
// Shared constants and types for the mailbox command processor.
// Assumes an 8-bit host data path and a 4-bit byte address.
package mbox_pkg;

    localparam int BYTE_W = 8;

    // Operation codes with fixed meaning
    localparam logic [7:0] OP_CLEAR     = 8'h00;
    localparam logic [7:0] OP_LOAD_OUT  = 8'h01;
    localparam logic [7:0] OP_READ_OUT  = 8'h02;
    localparam logic [7:0] OP_QUERY     = 8'h03;

    // Register window addresses
    localparam logic [3:0] AD_ARG_LO   = 4'd0;
    localparam logic [3:0] AD_ARG_HI   = 4'd1;
    localparam logic [3:0] AD_OPCODE   = 4'd2;
    localparam logic [3:0] AD_OPAD     = 4'd3;
    localparam logic [3:0] AD_RES_LO   = 4'd4;
    localparam logic [3:0] AD_RES_HI   = 4'd5;
    localparam logic [3:0] AD_ACK      = 4'd6;
    localparam logic [3:0] AD_INPUTS   = 4'd7;
    localparam logic [3:0] AD_ICTL_LO  = 4'd8;
    localparam logic [3:0] AD_ICTL_EN  = 4'd9;
    localparam logic [3:0] AD_ISTATUS  = 4'd10;
    localparam logic [3:0] AD_ICTL_HI  = 4'd11;

    // Interrupt bit positions
    localparam int IEN_BIT     = 5;
    localparam int ST_PEND_BIT = 0;
    localparam int ST_DONE_BIT = 1;
    localparam int ST_ANY_BIT  = 6;
    localparam int ST_REQ_BIT  = 7;

    typedef struct packed {
        logic [7:0]  code;
        logic [15:0] arg;
    } mbox_req_t;

endpackage

// File: rtl/mbox_sampler.sv
// Input snapshot: synchronises the asynchronous input levels through
// SYNC_N flops and captures them on a tick every DIV cycles.
// Assumes DIV >= 2 and SYNC_N >= 1.
module mbox_sampler #(
    parameter int DIV    = 5000,
    parameter int W      = 8,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] snap
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0]  sync_q [SYNC_N];
    logic [CW-1:0] pre_q;
    logic          tick;
    logic [W-1:0]  snap_q;

    // Synchroniser chain, stage 0 samples the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_N; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= din;
            for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign tick = (pre_q == CW'(DIV - 1));

    // Refresh prescaler, wraps every DIV cycles
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // Snapshot register loaded on the tick
    always_ff @(posedge clk) begin
        if (!rst_n)    snap_q <= '0;
        else if (tick) snap_q <= sync_q[SYNC_N-1];
    end

    assign snap = snap_q;

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(snap_q));

endmodule

// File: rtl/mbox_exec.sv
// Command engine: accepts a request when idle, waits LAT cycles, then
// decodes the captured code, updates the relay latch or the settings
// bank, and publishes the acknowledge code and the 16-bit result.
// Assumes LAT >= 1, SET_N >= 2, and a settings range that stays clear of codes 0x00-0x03.
module mbox_exec
    import mbox_pkg::*;
#(
    parameter int         LAT      = 4,
    parameter int         BUDGET   = 12500,
    parameter logic [7:0] SET_BASE = 8'h10,
    parameter int         SET_N    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  mbox_req_t         req,
    output logic              busy,
    output logic              accept,
    output logic              finish,
    output logic [7:0]        ack,
    output logic [15:0]       result,
    output logic [BYTE_W-1:0] relay
);
    localparam int CW  = $clog2(LAT + 1);
    localparam int IW  = $clog2(SET_N);
    localparam int BW  = $clog2(BUDGET + 1);

    logic              busy_q;
    logic [CW-1:0]     cnt_q;
    mbox_req_t         cmd_q;
    logic [7:0]        ack_q;
    logic [15:0]       res_q;
    logic [BYTE_W-1:0] relay_q;
    logic [SET_N*16-1:0] bank_flat;

    logic [8:0]    code_off, sel_off;
    logic          code_in_bank, sel_in_bank;
    logic [IW-1:0] code_idx, sel_idx;
    logic [7:0]    sel;
    logic [7:0]    ack_nx;
    logic [15:0]   res_nx;
    logic          do_load;

    assign accept = start_wr && !busy_q;
    assign finish = busy_q && (cnt_q == '0);
    assign sel    = cmd_q.arg[7:0];

    assign code_off     = {1'b0, cmd_q.code} - {1'b0, SET_BASE};
    assign sel_off      = {1'b0, sel} - {1'b0, SET_BASE};
    assign code_in_bank = (cmd_q.code >= SET_BASE) && (code_off < 9'(SET_N));
    assign sel_in_bank  = (sel >= SET_BASE) && (sel_off < 9'(SET_N));
    assign code_idx     = code_off[IW-1:0];
    assign sel_idx      = sel_off[IW-1:0];

    // Decode of the captured command into acknowledge, result and latch load
    always_comb begin
        ack_nx  = cmd_q.code;
        res_nx  = 16'h0000;
        do_load = 1'b0;
        case (cmd_q.code)
            OP_CLEAR:    ack_nx = 8'h00;
            OP_LOAD_OUT: begin
                do_load = 1'b1;
                res_nx  = 16'(cmd_q.arg[BYTE_W-1:0]);
            end
            OP_READ_OUT: res_nx = 16'(relay_q);
            OP_QUERY: begin
                if (sel_in_bank)            res_nx = bank_flat[sel_idx*16 +: 16];
                else if (sel == OP_LOAD_OUT) res_nx = 16'(relay_q);
            end
            default: ;
        endcase
    end

    // Sequencer: capture on accept, count down, release on finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cmd_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(LAT - 1);
            cmd_q  <= req;
        end else if (finish) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Result publication and relay latch update on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 8'h00;
            res_q   <= 16'h0000;
            relay_q <= '0;
        end else if (finish) begin
            ack_q <= ack_nx;
            res_q <= res_nx;
            if (do_load) relay_q <= cmd_q.arg[BYTE_W-1:0];
        end
    end

    // Settings bank, one register per code in the range
    for (genvar g = 0; g < SET_N; g++) begin : g_bank
        logic [15:0] val_q;
        // Store the argument when this entry's code completes
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= 16'h0000;
            else if (finish && code_in_bank && (code_idx == IW'(g)))
                val_q <= cmd_q.arg;
        end
        assign bank_flat[g*16 +: 16] = val_q;
    end

    assign busy   = busy_q;
    assign ack    = ack_q;
    assign result = res_q;
    assign relay  = relay_q;

    // In-flight watch counter for the completion budget
    logic [BW-1:0] watch_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_q) watch_q <= '0;
        else                   watch_q <= watch_q + 1'b1;
    end

    // R3
    busy_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (watch_q < BW'(BUDGET)));

    // R4
    latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (relay_q != $past(relay_q)) |-> (ack_q == OP_LOAD_OUT));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && busy_q) |=> (cmd_q == $past(cmd_q)));

endmodule

// File: rtl/mbox_irq.sv
// Interrupt control and status: a host-writable enable, a pending flag
// for the command in flight, and a completion event cleared by a read
// of the acknowledge byte. Assumes accept and finish never coincide.
module mbox_irq
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              finish,
    input  logic              ack_rd,
    input  logic              en_wr,
    input  logic              en_bit,
    output logic              en,
    output logic [BYTE_W-1:0] status,
    output logic              irq
);
    logic en_q, pend_q, done_q, any;

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_wr) en_q <= en_bit;
    end

    // Pending flag for the command in flight
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (accept) pend_q <= 1'b1;
        else if (finish) pend_q <= 1'b0;
    end

    // Completion event, a new completion beats the clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)      done_q <= 1'b0;
        else if (finish) done_q <= 1'b1;
        else if (ack_rd) done_q <= 1'b0;
    end

    assign any = pend_q | done_q;

    // Status byte assembly
    always_comb begin
        status              = '0;
        status[ST_PEND_BIT] = pend_q;
        status[ST_DONE_BIT] = done_q;
        status[ST_ANY_BIT]  = any;
        status[ST_REQ_BIT]  = any & en_q;
    end

    assign en  = en_q;
    assign irq = status[ST_REQ_BIT];

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en_q);

    // R11
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !finish) |=> !done_q);

endmodule

// File: rtl/mbox_cmd_unit.sv
// Top of the mailbox command processor: holds the outgoing argument and
// opcode bytes, starts a command on an opcode write, and multiplexes the
// incoming bytes, input snapshot and interrupt bytes onto the read port.
// Assumes single-cycle host strobes and a combinational read path.
module mbox_cmd_unit
    import mbox_pkg::*;
#(
    parameter int         TICK_DIV = 5000,
    parameter int         EXEC_LAT = 4,
    parameter int         BUDGET   = 12500,
    parameter logic [7:0] SET_BASE = 8'h10,
    parameter int         SET_N    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [3:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [7:0]  iso_in,
    output logic [7:0]  relay_out,
    output logic        irq_o
);
    logic [7:0]  arg_lo_q, arg_hi_q, opcode_q;
    logic        start_wr, busy, accept, finish, en;
    logic [7:0]  ack, snap, status;
    logic [15:0] result;
    mbox_req_t   req;

    assign start_wr = host_wr && (host_addr == AD_OPCODE);
    assign req      = '{code: host_wdata, arg: {arg_hi_q, arg_lo_q}};

    // Outgoing byte registers, always reflect the last host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_lo_q <= 8'h00;
            arg_hi_q <= 8'h00;
            opcode_q <= 8'h00;
        end else if (host_wr) begin
            case (host_addr)
                AD_ARG_LO: arg_lo_q <= host_wdata;
                AD_ARG_HI: arg_hi_q <= host_wdata;
                AD_OPCODE: opcode_q <= host_wdata;
                default: ;
            endcase
        end
    end

    mbox_exec #(
        .LAT      (EXEC_LAT),
        .BUDGET   (BUDGET),
        .SET_BASE (SET_BASE),
        .SET_N    (SET_N)
    ) i_exec (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .req      (req),
        .busy     (busy),
        .accept   (accept),
        .finish   (finish),
        .ack      (ack),
        .result   (result),
        .relay    (relay_out)
    );

    mbox_sampler #(
        .DIV    (TICK_DIV),
        .W      (BYTE_W),
        .SYNC_N (2)
    ) i_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (iso_in),
        .snap  (snap)
    );

    mbox_irq i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .finish (finish),
        .ack_rd (host_rd && (host_addr == AD_ACK)),
        .en_wr  (host_wr && (host_addr == AD_ICTL_EN)),
        .en_bit (host_wdata[IEN_BIT]),
        .en     (en),
        .status (status),
        .irq    (irq_o)
    );

    // Read multiplexer over the register window
    always_comb begin
        host_rdata = 8'h00;
        case (host_addr)
            AD_ARG_LO:  host_rdata = arg_lo_q;
            AD_ARG_HI:  host_rdata = arg_hi_q;
            AD_OPCODE:  host_rdata = opcode_q;
            AD_RES_LO:  host_rdata = result[7:0];
            AD_RES_HI:  host_rdata = result[15:8];
            AD_ACK:     host_rdata = ack;
            AD_INPUTS:  host_rdata = snap;
            AD_ICTL_EN: host_rdata = 8'(en) << IEN_BIT;
            AD_ISTATUS: host_rdata = status;
            default:    host_rdata = 8'h00;
        endcase
    end

    // R3
    pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> status[ST_PEND_BIT]);

endmodule

// File: tb/test_mbox_cmd_unit.sv
module test_mbox_cmd_unit;
    localparam int DIV = 8;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0] host_addr = 4'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] iso_in = 8'h00;
    logic [7:0] relay_out;
    logic       irq_o;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mbox_cmd_unit #(.TICK_DIV(DIV), .EXEC_LAT(LAT), .BUDGET(12),
                    .SET_BASE(8'h10), .SET_N(16)) i_mbox_cmd_unit (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .iso_in(iso_in), .relay_out(relay_out), .irq_o(irq_o));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input [3:0] a, input [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input [3:0] a, output [7:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic issue(input [7:0] code, input [15:0] p, output int polls);
        logic [7:0] v;
        wr(4'd0, p[7:0]); wr(4'd1, p[15:8]); wr(4'd2, code);
        polls = -1;
        for (int i = 0; i < 20; i++) begin
            rd(4'd6, v);
            if (v == code) begin polls = i; break; end
        end
        idle(LAT + 1);
    endtask

    task automatic result16(output [15:0] r);
        logic [7:0] lo, hi;
        rd(4'd4, lo); rd(4'd5, hi);
        r = {hi, lo};
    endtask

    task automatic query(input [7:0] sel, output [15:0] r);
        int p;
        issue(8'h00, 16'h0000, p);
        issue(8'h03, {8'h00, sel}, p);
        chk("R6 query completion", (p >= 0) ? 1 : 0, 1);
        result16(r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] r;
        int p;
        int k;

        idle(5);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state of every register and output
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 reset addr %0d", a), v, 0);
        end
        chk("R1 relay reset", relay_out, 0);
        chk("R1 irq reset", irq_o, 0);

        // R2: outgoing bytes read back, pad byte stays zero
        wr(4'd0, 8'hA7); wr(4'd1, 8'h3C); wr(4'd3, 8'hFF);
        rd(4'd0, v); chk("R2 arg lo readback", v, 8'hA7);
        rd(4'd1, v); chk("R2 arg hi readback", v, 8'h3C);
        rd(4'd3, v); chk("R2 pad reads zero", v, 0);

        // R3: exact latency after clear, relay read
        issue(8'h00, 16'h0000, p);
        issue(8'h02, 16'h0000, p);
        chk("R3 completion latency", p, LAT);

        // R4: sweep every latch value, alternating load and read
        for (int x = 0; x < 256; x++) begin
            issue(8'h01, {~8'(x), 8'(x)}, p);
            chk("R4 load completion", (p >= 0) ? 1 : 0, 1);
            chk("R4 relay_out", relay_out, x);
            result16(r);
            chk("R4 load result", r, x);
            issue(8'h02, 16'hFFFF, p);
            result16(r);
            chk("R4 read result", r, x);
            chk("R4 read keeps latch", relay_out, x);
        end

        // R5: clear zeroes ack and result, repeat detected
        issue(8'h00, 16'h1234, p);
        rd(4'd6, v); chk("R5 ack cleared", v, 0);
        result16(r); chk("R5 result cleared", r, 0);
        issue(8'h02, 16'h0000, p);
        chk("R5 repeat after clear detected", p, LAT);

        // R6: settings bank store and query
        for (int g = 0; g < 16; g++) begin
            issue(8'(8'h10 + g), 16'(g * 16'h1111) ^ 16'hA5C3, p);
            result16(r); chk("R6 store result zero", r, 0);
        end
        for (int g = 0; g < 16; g++) begin
            query(8'(8'h10 + g), r);
            chk($sformatf("R6 query entry %0d", g), r, 16'(g * 16'h1111) ^ 16'hA5C3);
        end
        query(8'h01, r); chk("R6 query latch", r, 8'hFF);
        query(8'h0F, r); chk("R6 query below range", r, 0);
        query(8'h20, r); chk("R6 query above range", r, 0);

        // R7: unknown code echoes with zero result, latch untouched
        issue(8'h7E, 16'hFFFF, p);
        chk("R7 unknown echoed", (p >= 0) ? 1 : 0, 1);
        result16(r); chk("R7 unknown result", r, 0);
        chk("R7 latch untouched", relay_out, 8'hFF);

        // R8: writes while busy start nothing, argument captured at accept
        issue(8'h02, 16'h0000, p);
        wr(4'd0, 8'h11); wr(4'd1, 8'h00); wr(4'd2, 8'h01);
        wr(4'd0, 8'h22); wr(4'd2, 8'h7E);
        idle(2);
        chk("R8 relay from captured arg", relay_out, 8'h11);
        rd(4'd6, v); chk("R8 ack is first command", v, 8'h01);
        result16(r); chk("R8 result from captured arg", r, 8'h11);
        idle(12);
        rd(4'd6, v); chk("R8 second write never ran", v, 8'h01);
        rd(4'd2, v); chk("R2 opcode byte holds last write", v, 8'h7E);

        // R11: completion and clearing read in the same cycle
        issue(8'h00, 16'h0000, p);
        wr(4'd0, 8'h5A); wr(4'd1, 8'h00); wr(4'd2, 8'h01);
        idle(3);
        rd(4'd6, v); chk("R11 read on completion edge sees old ack", v, 0);
        rd(4'd10, v); chk("R11 completion wins over clear", v, 8'h42);
        rd(4'd6, v); chk("R11 ack after completion", v, 8'h01);
        rd(4'd10, v); chk("R11 event cleared by read", v, 0);

        // R10: enable, pending and gated request
        wr(4'd9, 8'hFF);
        rd(4'd9, v); chk("R10 enable readback", v, 8'h20);
        rd(4'd8, v); chk("R10 ctrl lo zero", v, 0);
        rd(4'd11, v); chk("R10 ctrl hi zero", v, 0);
        chk("R10 irq idle", irq_o, 0);
        wr(4'd2, 8'h02);
        rd(4'd10, v); chk("R10 pending status", v, 8'hC1);
        chk("R10 irq while pending", irq_o, 1);
        idle(3);
        rd(4'd10, v); chk("R10 done status", v, 8'hC2);
        chk("R10 irq on done", irq_o, 1);
        wr(4'd9, 8'h00);
        rd(4'd10, v); chk("R10 masked status", v, 8'h42);
        chk("R10 irq masked", irq_o, 0);
        rd(4'd6, v);
        rd(4'd10, v); chk("R10 status idle", v, 0);

        // R9: input snapshot sweep
        for (int x = 0; x < 256; x++) begin
            iso_in = 8'(x);
            idle(DIV + 4);
            rd(4'd7, v);
            chk("R9 snapshot value", v, x);
        end

        // R9: snapshot holds between ticks
        iso_in = 8'h3C;
        k = -1;
        for (int i = 0; i < 4 * DIV; i++) begin
            rd(4'd7, v);
            if (v == 8'h3C) begin k = i; break; end
        end
        chk("R9 snapshot refreshed", (k >= 0) ? 1 : 0, 1);
        iso_in = 8'hC3;
        for (int i = 0; i < DIV - 1; i++) begin
            rd(4'd7, v);
            chk("R9 hold between ticks", v, 8'h3C);
        end
        rd(4'd7, v); chk("R9 next tick takes new level", v, 8'hC3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule